// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide host-facing programming interface of an eight-input interrupt controller. It has two byte addresses. Writes to the first address are sorted by their flag bits into three groups: start-of-initialization words, read/poll commands and operation commands. Writes to the second address either load the mask or supply the remaining initialization words, depending on where a four-state setup sequencer stands. Reads return the request, in-service or mask register supplied by the priority core. Reads can instead return a one-shot poll word that also acknowledges the winning input.

The priority core itself is a separate block. This port hands it mode flags and one-cycle command strobes, each carrying a 3-bit operand. It receives the core's register values and the core's current poll answer in return. A separate one-byte trigger-mode register sits beside the port. Its write value is filtered through a fixed per-instance enable mask.

Top module: `intc_prog_port`

## Requirements
- R1: After reset the sequencer is in state 0, every mode flag, the vector base and the trigger-mode register are zero, and no strobe is active.
- R2: A write to address 0 with bit 4 set pulses `core_init_stb` for one cycle. It records `need_mode_word` from bit 0 and `single_mode` from bit 1, moves the sequencer to state 1, and clears vector base, nested mode, auto-EOI, rotate-on-auto-EOI, special mask, read-select and poll.
- R3: In state 1 a write to address 1 stores bits 7:3 as `vec_base`. The next state is 3 when single mode and the mode word are both set, 0 when single mode is set without the mode word, and 2 when single mode is clear.
- R4: In state 2 a write to address 1 goes to state 3 if the mode word is needed and to state 0 otherwise. In state 3 a write to address 1 sets `nested_mode` from bit 4 and `auto_eoi` from bit 1, then returns to state 0.
- R5: In state 0 a write to address 1 raises `mask_stb` for exactly one cycle with `mask_val` equal to the written byte.
- R6: A write to address 0 with bit 4 clear and bit 3 set is a read/poll command. Bit 2 set arms poll. Bit 1 set copies bit 0 into `read_isr_sel`. Bit 6 set copies bit 5 into `special_mask`. Clear enable bits leave the matching flag unchanged.
- R7: An operation command (bits 4 and 3 clear) with code 0 or 4 in bits 7:5 sets `rot_on_aeoi` to bit 7. Code 2 changes no flag and raises no strobe.
- R8: Operation codes 1, 5, 3, 6 and 7 raise, for one cycle, `eoi_ns_stb`, `eoi_ns_rot_stb`, `eoi_sp_stb`, `set_prio_stb` and `eoi_sp_rot_stb` respectively, with `op_arg` equal to bits 2:0. At most one strobe is active at a time.
- R9: While poll is armed, `rdata` is 0x80 OR `poll_irq` if `poll_hit` is set, and 0 otherwise. A read in that state disarms poll. When a hit was present, the read also raises `ack_stb` for one cycle, next cycle, with `ack_irq` equal to the polled number.
- R10: With poll disarmed, `rdata` at address 0 is `core_isr` when `read_isr_sel` is set and `core_irr` otherwise; at address 1 it is `core_imr`.
- R11: A trigger-mode write stores `trig_wdata` AND the parameter `TRIG_EN_MASK` (default 0xF8); the register holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 1 | Port address (0 or 1) |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte (combinational) |
| trig_wr_en | input | 1 | Trigger-mode register write |
| trig_wdata | input | 8 | Trigger-mode write byte |
| trig_mode | output | 8 | Trigger-mode register value |
| core_irr | input | 8 | Request register from core |
| core_isr | input | 8 | In-service register from core |
| core_imr | input | 8 | Mask register from core |
| poll_hit | input | 1 | Core has a winning request |
| poll_irq | input | 3 | Winning input number |
| core_init_stb | output | 1 | Core reset pulse |
| mask_stb | output | 1 | Mask load pulse |
| mask_val | output | 8 | Mask value |
| eoi_ns_stb | output | 1 | Non-specific EOI pulse |
| eoi_ns_rot_stb | output | 1 | Non-specific EOI with rotation pulse |
| eoi_sp_stb | output | 1 | Specific EOI pulse |
| eoi_sp_rot_stb | output | 1 | Rotate on specific EOI pulse |
| set_prio_stb | output | 1 | Set lowest priority pulse |
| op_arg | output | 3 | Operand for command pulses |
| ack_stb | output | 1 | Poll acknowledge pulse |
| ack_irq | output | 3 | Acknowledged input number |
| seq_state | output | 2 | Setup sequencer state |
| single_mode | output | 1 | Single-controller mode |
| need_mode_word | output | 1 | Fourth setup word expected |
| vec_base | output | 5 | Vector base bits 7:3 |
| nested_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic EOI mode |
| rot_on_aeoi | output | 1 | Rotate on automatic EOI |
| special_mask | output | 1 | Special mask mode |
| read_isr_sel | output | 1 | Readback selects in-service register |
| poll_armed | output | 1 | Next read is a poll read |

## Verification
The assertions assume that the host never issues a read and a write in the same cycle. A read landing on a write could otherwise rearm and disarm poll at once. They also assume that `poll_hit` and `poll_irq` are steady across a read cycle. The bench drives every access as a single-cycle pulse with an idle cycle after it. It changes the core-side values only while no access is in flight, so strobes never overlap and each one can be matched in order against the scoreboard queue.

// File: rtl/intc_cmd_pkg.sv
package intc_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int IRQ_W  = 3;
  localparam int BASE_W = 5;
  localparam int NUM_OP = 5;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    P0_INIT   = 2'd0,
    P0_RDPOLL = 2'd1,
    P0_OPCMD  = 2'd2
  } p0_kind_e;

  // strobe slots in the operation strobe vector
  localparam int OPS_NS     = 0;
  localparam int OPS_NS_ROT = 1;
  localparam int OPS_SP     = 2;
  localparam int OPS_PRIO   = 3;
  localparam int OPS_SP_ROT = 4;

  function automatic p0_kind_e p0_kind(input logic [BYTE_W-1:0] d);
    if (d[4])      return P0_INIT;
    else if (d[3]) return P0_RDPOLL;
    else           return P0_OPCMD;
  endfunction

  function automatic seq_state_e seq_after_base(input logic single, input logic need4);
    if (!single)   return SEQ_CASC;
    else if (need4) return SEQ_MODE;
    else           return SEQ_IDLE;
  endfunction

  function automatic seq_state_e seq_after_casc(input logic need4);
    return need4 ? SEQ_MODE : SEQ_IDLE;
  endfunction

  // one-hot strobe pattern for an operation code, zero when no strobe
  function automatic logic [NUM_OP-1:0] op_strobes(input logic [2:0] code);
    logic [NUM_OP-1:0] s;
    s = '0;
    case (code)
      3'd1: s[OPS_NS]     = 1'b1;
      3'd5: s[OPS_NS_ROT] = 1'b1;
      3'd3: s[OPS_SP]     = 1'b1;
      3'd6: s[OPS_PRIO]   = 1'b1;
      3'd7: s[OPS_SP_ROT] = 1'b1;
      default: s = '0;
    endcase
    return s;
  endfunction

  function automatic logic [BYTE_W-1:0] poll_word(input logic hit, input logic [IRQ_W-1:0] irq);
    logic [BYTE_W-1:0] w;
    w = '0;
    if (hit) begin
      w[BYTE_W-1]  = 1'b1;
      w[IRQ_W-1:0] = irq;
    end
    return w;
  endfunction
endpackage

// File: rtl/intc_init_seq.sv
module intc_init_seq
  import intc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_wr,
  input  logic              port1_wr,
  input  logic [BYTE_W-1:0] wdata,
  output seq_state_e        state,
  output logic              single,
  output logic              need4,
  output logic [BASE_W-1:0] vec_base,
  output logic              nested,
  output logic              aeoi,
  output logic              init_pulse,
  output logic              mask_pulse,
  output logic [BYTE_W-1:0] mask_val
);
  seq_state_e        state_q;
  logic              single_q, need4_q, nested_q, aeoi_q;
  logic [BASE_W-1:0] base_q;
  logic              init_q, mask_q;
  logic [BYTE_W-1:0] mask_val_q;

  // named internal events
  logic base_word, casc_word, mode_word, mask_word;
  assign base_word = port1_wr && (state_q == SEQ_BASE);
  assign casc_word = port1_wr && (state_q == SEQ_CASC);
  assign mode_word = port1_wr && (state_q == SEQ_MODE);
  assign mask_word = port1_wr && (state_q == SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
      nested_q <= 1'b0;
      aeoi_q   <= 1'b0;
      base_q   <= '0;
    end else if (init_wr) begin
      state_q  <= SEQ_BASE;
      need4_q  <= wdata[0];
      single_q <= wdata[1];
      nested_q <= 1'b0;
      aeoi_q   <= 1'b0;
      base_q   <= '0;
    end else if (base_word) begin
      base_q  <= wdata[BYTE_W-1:BYTE_W-BASE_W];
      state_q <= seq_after_base(single_q, need4_q);
    end else if (casc_word) begin
      state_q <= seq_after_casc(need4_q);
    end else if (mode_word) begin
      nested_q <= wdata[4];
      aeoi_q   <= wdata[1];
      state_q  <= SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q     <= 1'b0;
      mask_q     <= 1'b0;
      mask_val_q <= '0;
    end else begin
      init_q <= init_wr;
      mask_q <= mask_word;
      if (mask_word) mask_val_q <= wdata;
    end
  end

  assign state      = state_q;
  assign single     = single_q;
  assign need4      = need4_q;
  assign vec_base   = base_q;
  assign nested     = nested_q;
  assign aeoi       = aeoi_q;
  assign init_pulse = init_q;
  assign mask_pulse = mask_q;
  assign mask_val   = mask_val_q;

  // R2: an initialization word always lands in the base-wait state
  a_r2_init_enters_base: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (state_q == SEQ_BASE) && init_q);

  // R4: the mode word always ends the sequence
  a_r4_mode_word_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_word && !init_wr) |=> (state_q == SEQ_IDLE));

  // R3: vector base moves only on the base word or an init word
  a_r3_base_only_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(base_q) |-> ($past(state_q) == SEQ_BASE) || $past(init_wr));

  // R5: the mask strobe only follows a write in the idle state
  a_r5_mask_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> $past(port1_wr) && ($past(state_q) == SEQ_IDLE));
endmodule

// File: rtl/intc_ocw_decode.sv
module intc_ocw_decode
  import intc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_wr,
  input  logic              rdpoll_wr,
  input  logic              opcmd_wr,
  input  logic              poll_take,
  input  logic [BYTE_W-1:0] wdata,
  output logic              poll_armed,
  output logic              rd_isr_sel,
  output logic              smm,
  output logic              rot_aeoi,
  output logic [NUM_OP-1:0] op_stb,
  output logic [IRQ_W-1:0]  op_arg
);
  logic              poll_q, rsel_q, smm_q, rot_q;
  logic [NUM_OP-1:0] stb_q;
  logic [IRQ_W-1:0]  arg_q;

  logic [2:0] opcode;
  logic       rot_cfg_cmd;
  assign opcode      = wdata[7:5];
  assign rot_cfg_cmd = opcmd_wr && (opcode[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q <= 1'b0;
      rsel_q <= 1'b0;
      smm_q  <= 1'b0;
      rot_q  <= 1'b0;
    end else if (init_wr) begin
      poll_q <= 1'b0;
      rsel_q <= 1'b0;
      smm_q  <= 1'b0;
      rot_q  <= 1'b0;
    end else begin
      if (rdpoll_wr) begin
        if (wdata[2]) poll_q <= 1'b1;
        if (wdata[1]) rsel_q <= wdata[0];
        if (wdata[6]) smm_q  <= wdata[5];
      end else if (poll_take) begin
        poll_q <= 1'b0;
      end
      if (rot_cfg_cmd) rot_q <= opcode[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
      arg_q <= '0;
    end else begin
      stb_q <= opcmd_wr ? op_strobes(opcode) : '0;
      if (opcmd_wr) arg_q <= wdata[IRQ_W-1:0];
    end
  end

  assign poll_armed = poll_q;
  assign rd_isr_sel = rsel_q;
  assign smm        = smm_q;
  assign rot_aeoi   = rot_q;
  assign op_stb     = stb_q;
  assign op_arg     = arg_q;

  // R8: never more than one command strobe at once
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_q));

  // R9: a poll read disarms poll
  a_r9_poll_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !rdpoll_wr && !init_wr) |=> !poll_q);

  // R7: code 2 touches no flag and raises no strobe
  a_r7_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (opcmd_wr && opcode == 3'd2) |=> $stable(rot_q) && (stb_q == '0));
endmodule

// File: rtl/intc_readback.sv
module intc_readback
  import intc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              addr,
  input  logic              poll_armed,
  input  logic              rd_isr_sel,
  input  logic [BYTE_W-1:0] irr,
  input  logic [BYTE_W-1:0] isr,
  input  logic [BYTE_W-1:0] imr,
  input  logic              poll_hit,
  input  logic [IRQ_W-1:0]  poll_irq,
  output logic [BYTE_W-1:0] rdata,
  output logic              poll_take,
  output logic              ack_stb,
  output logic [IRQ_W-1:0]  ack_irq
);
  logic             ack_q;
  logic [IRQ_W-1:0] ack_irq_q;
  logic             ack_event;

  assign poll_take = rd_en && poll_armed;
  assign ack_event = poll_take && poll_hit;

  always_comb begin
    if (poll_armed)      rdata = poll_word(poll_hit, poll_irq);
    else if (addr)       rdata = imr;
    else if (rd_isr_sel) rdata = isr;
    else                 rdata = irr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q     <= 1'b0;
      ack_irq_q <= '0;
    end else begin
      ack_q <= ack_event;
      if (ack_event) ack_irq_q <= poll_irq;
    end
  end

  assign ack_stb = ack_q;
  assign ack_irq = ack_irq_q;

  // R9: an acknowledge only follows a poll read that found a hit
  a_r9_ack_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> $past(poll_take) && $past(poll_hit));
endmodule

// File: rtl/intc_trig_reg.sv
module intc_trig_reg
  import intc_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] EN_MASK = 8'hF8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] mode
);
  logic [BYTE_W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mode_q <= '0;
    else if (wr) mode_q <= wdata & EN_MASK;
  end

  assign mode = mode_q;

  // R11: the register holds when not written
  a_r11_trig_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mode_q));
endmodule

// File: rtl/intc_prog_port.sv
module intc_prog_port
  import intc_cmd_pkg::*;
#(
  parameter logic [7:0] TRIG_EN_MASK = 8'hF8
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       trig_wr_en,
  input  logic [7:0] trig_wdata,
  output logic [7:0] trig_mode,
  input  logic [7:0] core_irr,
  input  logic [7:0] core_isr,
  input  logic [7:0] core_imr,
  input  logic       poll_hit,
  input  logic [2:0] poll_irq,
  output logic       core_init_stb,
  output logic       mask_stb,
  output logic [7:0] mask_val,
  output logic       eoi_ns_stb,
  output logic       eoi_ns_rot_stb,
  output logic       eoi_sp_stb,
  output logic       eoi_sp_rot_stb,
  output logic       set_prio_stb,
  output logic [2:0] op_arg,
  output logic       ack_stb,
  output logic [2:0] ack_irq,
  output logic [1:0] seq_state,
  output logic       single_mode,
  output logic       need_mode_word,
  output logic [4:0] vec_base,
  output logic       nested_mode,
  output logic       auto_eoi,
  output logic       rot_on_aeoi,
  output logic       special_mask,
  output logic       read_isr_sel,
  output logic       poll_armed
);
  logic       port0_wr, port1_wr;
  logic       init_wr, rdpoll_wr, opcmd_wr;
  logic       poll_take, poll_q, rsel;
  p0_kind_e   kind;
  seq_state_e st;
  logic [NUM_OP-1:0] op_stb;

  assign port0_wr  = wr_en && !addr;
  assign port1_wr  = wr_en && addr;
  assign kind      = p0_kind(wdata);
  assign init_wr   = port0_wr && (kind == P0_INIT);
  assign rdpoll_wr = port0_wr && (kind == P0_RDPOLL);
  assign opcmd_wr  = port0_wr && (kind == P0_OPCMD);

  intc_init_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_wr    (init_wr),
    .port1_wr   (port1_wr),
    .wdata      (wdata),
    .state      (st),
    .single     (single_mode),
    .need4      (need_mode_word),
    .vec_base   (vec_base),
    .nested     (nested_mode),
    .aeoi       (auto_eoi),
    .init_pulse (core_init_stb),
    .mask_pulse (mask_stb),
    .mask_val   (mask_val)
  );

  intc_ocw_decode u_ocw (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_wr    (init_wr),
    .rdpoll_wr  (rdpoll_wr),
    .opcmd_wr   (opcmd_wr),
    .poll_take  (poll_take),
    .wdata      (wdata),
    .poll_armed (poll_q),
    .rd_isr_sel (rsel),
    .smm        (special_mask),
    .rot_aeoi   (rot_on_aeoi),
    .op_stb     (op_stb),
    .op_arg     (op_arg)
  );

  intc_readback u_rb (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .addr       (addr),
    .poll_armed (poll_q),
    .rd_isr_sel (rsel),
    .irr        (core_irr),
    .isr        (core_isr),
    .imr        (core_imr),
    .poll_hit   (poll_hit),
    .poll_irq   (poll_irq),
    .rdata      (rdata),
    .poll_take  (poll_take),
    .ack_stb    (ack_stb),
    .ack_irq    (ack_irq)
  );

  intc_trig_reg #(.EN_MASK(TRIG_EN_MASK)) u_trig (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (trig_wr_en),
    .wdata (trig_wdata),
    .mode  (trig_mode)
  );

  assign seq_state      = st;
  assign poll_armed     = poll_q;
  assign read_isr_sel   = rsel;
  assign eoi_ns_stb     = op_stb[OPS_NS];
  assign eoi_ns_rot_stb = op_stb[OPS_NS_ROT];
  assign eoi_sp_stb     = op_stb[OPS_SP];
  assign set_prio_stb   = op_stb[OPS_PRIO];
  assign eoi_sp_rot_stb = op_stb[OPS_SP_ROT];

  // R1: nothing is strobed in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !core_init_stb && !mask_stb && !ack_stb);
endmodule

// File: tb/intc_prog_port_tb.sv
module intc_prog_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       trig_wr_en = 1'b0;
  logic [7:0] trig_wdata = 8'h00;
  logic [7:0] trig_mode;
  logic [7:0] core_irr = 8'h5A, core_isr = 8'h3C, core_imr = 8'h81;
  logic       poll_hit = 1'b0;
  logic [2:0] poll_irq = 3'd0;
  logic       core_init_stb, mask_stb;
  logic [7:0] mask_val;
  logic       eoi_ns_stb, eoi_ns_rot_stb, eoi_sp_stb, eoi_sp_rot_stb, set_prio_stb;
  logic [2:0] op_arg;
  logic       ack_stb;
  logic [2:0] ack_irq;
  logic [1:0] seq_state;
  logic       single_mode, need_mode_word;
  logic [4:0] vec_base;
  logic       nested_mode, auto_eoi, rot_on_aeoi, special_mask, read_isr_sel, poll_armed;

  always #5 clk = ~clk;

  intc_prog_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .trig_wr_en(trig_wr_en), .trig_wdata(trig_wdata),
    .trig_mode(trig_mode), .core_irr(core_irr), .core_isr(core_isr), .core_imr(core_imr),
    .poll_hit(poll_hit), .poll_irq(poll_irq), .core_init_stb(core_init_stb),
    .mask_stb(mask_stb), .mask_val(mask_val), .eoi_ns_stb(eoi_ns_stb),
    .eoi_ns_rot_stb(eoi_ns_rot_stb), .eoi_sp_stb(eoi_sp_stb), .eoi_sp_rot_stb(eoi_sp_rot_stb),
    .set_prio_stb(set_prio_stb), .op_arg(op_arg), .ack_stb(ack_stb), .ack_irq(ack_irq),
    .seq_state(seq_state), .single_mode(single_mode), .need_mode_word(need_mode_word),
    .vec_base(vec_base), .nested_mode(nested_mode), .auto_eoi(auto_eoi),
    .rot_on_aeoi(rot_on_aeoi), .special_mask(special_mask), .read_isr_sel(read_isr_sel),
    .poll_armed(poll_armed)
  );

  // scoreboard event kinds
  localparam logic [3:0] K_NONE = 4'd0, K_INIT = 4'd1, K_MASK = 4'd2, K_NS = 4'd3,
                         K_NSR = 4'd4, K_SP = 4'd5, K_PRIO = 4'd6, K_SPR = 4'd7, K_ACK = 4'd8;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [11:0] exp_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the expected strobe for every strobe seen
  logic [11:0] seen;
  int          nstb;
  logic [11:0] want;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      nstb = int'(core_init_stb) + int'(mask_stb) + int'(eoi_ns_stb) + int'(eoi_ns_rot_stb)
           + int'(eoi_sp_stb) + int'(set_prio_stb) + int'(eoi_sp_rot_stb) + int'(ack_stb);
      seen = {K_NONE, 8'h00};
      if (core_init_stb)  seen = {K_INIT, 8'h00};
      if (mask_stb)       seen = {K_MASK, mask_val};
      if (eoi_ns_stb)     seen = {K_NS,   5'd0, op_arg};
      if (eoi_ns_rot_stb) seen = {K_NSR,  5'd0, op_arg};
      if (eoi_sp_stb)     seen = {K_SP,   5'd0, op_arg};
      if (set_prio_stb)   seen = {K_PRIO, 5'd0, op_arg};
      if (eoi_sp_rot_stb) seen = {K_SPR,  5'd0, op_arg};
      if (ack_stb)        seen = {K_ACK,  5'd0, ack_irq};
      if (nstb > 1) begin
        check("R8 strobe count", nstb, 1);
      end else if (nstb == 1) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected strobe", {20'd0, seen}, 32'd0);
        end else begin
          want = exp_q.pop_front();
          check("R5/R8/R9 strobe event", {20'd0, seen}, {20'd0, want});
        end
      end
    end
  end

  task automatic do_write(input logic a, input logic [7:0] d, input logic [3:0] k, input logic [7:0] kd);
    @(negedge clk);
    if (k != K_NONE) exp_q.push_back({k, kd});
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_read(input logic a, input string req, input logic [7:0] exp_d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 check(req, {24'd0, rdata}, {24'd0, exp_d});
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_trig(input logic [7:0] d);
    @(negedge clk);
    trig_wdata = d; trig_wr_en = 1'b1;
    @(negedge clk);
    trig_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 seq_state", seq_state, 0);
    check("R1 flags", {single_mode, need_mode_word, nested_mode, auto_eoi, rot_on_aeoi,
                       special_mask, read_isr_sel, poll_armed}, 0);
    check("R1 vec_base", vec_base, 0);
    check("R1 trig_mode", trig_mode, 0);
    check("R1 strobes", {core_init_stb, mask_stb, ack_stb, eoi_ns_stb, set_prio_stb}, 0);
    do_read(1'b0, "R10 irr readback", 8'h5A);

    // R11 trigger register masking
    do_trig(8'hFF);
    @(negedge clk);
    check("R11 trig masked", trig_mode, 8'hF8);
    do_trig(8'h0F);
    @(negedge clk);
    check("R11 trig masked low", trig_mode, 8'h08);

    // R2/R3/R4 cascaded path with mode word
    do_write(1'b0, 8'h80, K_NONE, 8'h00);        // rot_on_aeoi = 1, cleared by init below
    check("R7 code4 sets rotate", rot_on_aeoi, 1);
    do_write(1'b0, 8'h11, K_INIT, 8'h00);
    check("R2 state after init", seq_state, 1);
    check("R2 need/single", {need_mode_word, single_mode}, 2'b10);
    check("R2 init clears rotate", rot_on_aeoi, 0);
    do_write(1'b1, 8'h47, K_NONE, 8'h00);
    check("R3 vec_base", vec_base, 5'h08);
    check("R3 cascaded goes to 2", seq_state, 2);
    do_write(1'b1, 8'h04, K_NONE, 8'h00);
    check("R4 state2 to 3", seq_state, 3);
    do_write(1'b1, 8'h12, K_NONE, 8'h00);
    check("R4 mode flags", {nested_mode, auto_eoi}, 2'b11);
    check("R4 back to idle", seq_state, 0);

    // R5 mask load
    do_write(1'b1, 8'hA5, K_MASK, 8'hA5);
    check("R5 mask strobe gone", mask_stb, 0);
    do_read(1'b1, "R10 imr readback", 8'h81);

    // R3 single + mode word
    do_write(1'b0, 8'h13, K_INIT, 8'h00);
    check("R2 init clears mode flags", {nested_mode, auto_eoi, vec_base}, 0);
    do_write(1'b1, 8'h20, K_NONE, 8'h00);
    check("R3 single need4 to 3", seq_state, 3);
    do_write(1'b1, 8'h00, K_NONE, 8'h00);
    check("R4 mode word zero", {seq_state, nested_mode, auto_eoi}, 0);
    // R3 single without mode word
    do_write(1'b0, 8'h12, K_INIT, 8'h00);
    do_write(1'b1, 8'hF8, K_NONE, 8'h00);
    check("R3 single no need4 to 0", seq_state, 0);
    check("R3 vec_base top", vec_base, 5'h1F);
    // R4 cascaded without mode word
    do_write(1'b0, 8'h10, K_INIT, 8'h00);
    do_write(1'b1, 8'h08, K_NONE, 8'h00);
    check("R3 cascaded to 2", seq_state, 2);
    do_write(1'b1, 8'h00, K_NONE, 8'h00);
    check("R4 state2 to 0", seq_state, 0);

    // R7 rotate-on-auto-EOI and no-op
    do_write(1'b0, 8'h80, K_NONE, 8'h00);
    do_write(1'b0, 8'h47, K_NONE, 8'h00);     // code 2, no strobe
    check("R7 code2 keeps rotate", rot_on_aeoi, 1);
    do_write(1'b0, 8'h00, K_NONE, 8'h00);
    check("R7 code0 clears rotate", rot_on_aeoi, 0);

    // R8 command strobes
    do_write(1'b0, 8'h20, K_NS,   8'h00);
    do_write(1'b0, 8'hA2, K_NSR,  8'h02);
    do_write(1'b0, 8'h65, K_SP,   8'h05);
    do_write(1'b0, 8'hC3, K_PRIO, 8'h03);
    do_write(1'b0, 8'hE7, K_SPR,  8'h07);
    check("R8 strobe queue drained", exp_q.size(), 0);

    // R6 read-select and special mask
    do_write(1'b0, 8'h0B, K_NONE, 8'h00);
    check("R6 read select set", read_isr_sel, 1);
    do_read(1'b0, "R10 isr readback", 8'h3C);
    do_write(1'b0, 8'h09, K_NONE, 8'h00);
    check("R6 select gated off", read_isr_sel, 1);
    do_write(1'b0, 8'h0A, K_NONE, 8'h00);
    check("R6 read select clear", read_isr_sel, 0);
    do_write(1'b0, 8'h68, K_NONE, 8'h00);
    check("R6 special mask set", special_mask, 1);
    do_write(1'b0, 8'h28, K_NONE, 8'h00);
    check("R6 special mask gated", special_mask, 1);
    do_write(1'b0, 8'h48, K_NONE, 8'h00);
    check("R6 special mask clear", special_mask, 0);

    // R9 poll with a hit
    do_write(1'b0, 8'h0C, K_NONE, 8'h00);
    check("R6 poll armed", poll_armed, 1);
    poll_hit = 1'b1; poll_irq = 3'd5;
    exp_q.push_back({K_ACK, 8'h05});
    do_read(1'b0, "R9 poll word hit", 8'h85);
    check("R9 poll disarmed", poll_armed, 0);
    do_read(1'b0, "R9 normal read after poll", 8'h5A);
    // R9 poll without a hit
    poll_hit = 1'b0;
    do_write(1'b0, 8'h0C, K_NONE, 8'h00);
    do_read(1'b1, "R9 poll word empty", 8'h00);
    check("R9 poll disarmed empty", poll_armed, 0);
    repeat (3) @(negedge clk);
    check("R9 no stray ack", exp_q.size(), 0);
    finish_run();
  end
endmodule